// File: doc/BRIEF.md
# HDLC Receive Byte Buffer

This block sits between a bit-level HDLC deframer and a host. The deframer delivers received payload bytes one at a time, followed by a one-cycle frame-end strobe that carries the CRC verdict, or by an abort strobe. The block stores the bytes in a 32-byte buffer and hands them to the host in blocks. When the buffer fills in the middle of a frame, the host is interrupted to drain it. When a frame ends, a status byte is appended after the last data byte, the host is interrupted, and a residual byte count is exposed.

The host reads bytes in order from a single data-port address. It frees each block with a release command. It can also reset the receiver. A block that is waiting for the host accepts no new bytes. Bytes that arrive in that time are dropped, reported as an overflow, and marked in the status byte of the frame they belonged to. A frame end that arrives while a full block is still pending is held back. On release it is delivered as a one-byte block.

Host map (2-bit address): 0 is the data port (read). 1 is the interrupt status, cleared on read. 2 reads the byte count and takes commands on a write. 3 is the interrupt mask (read/write).

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After reset, irq is low and reads of status, count and mask all return 0x00.
- R2: Bytes are returned from address 0 in the order they arrived, one byte per read. The release command returns the read position to the first byte of the buffer.
- R3: When the 32nd byte of a block is written and the frame has not ended, status bit 6 (0x40) is set. Any byte that arrives while a block waits for release is dropped and sets status bit 5 (0x20).
- R4: At frame end, status bit 7 (0x80) is set and a status byte is stored after the last data byte. Its bit 7 means not aborted, bit 6 means a byte of this frame was dropped, bit 5 means CRC correct, bit 4 means aborted, and bits 3:0 are zero. A good frame therefore gives 0xA0.
- R5: The count register (address 2, bits 4:0) gives the number of bytes in the frame's final block, including the status byte. A full block of 32 reads as 0.
- R6: A write to address 2 with bit 7 set releases the pending block. A frame end that arrived while a full block was pending raises no event until that release. On release it becomes a block holding only the status byte (count 1) and sets status bit 7.
- R7: A write to address 2 with bit 6 set discards the buffer contents, any held-back frame end and the overflow mark. The next frame then starts at the first position.
- R8: Reading address 1 returns the status and clears it. An event at the same clock edge as the read stays set for the next read.
- R9: A 1 in a mask bit (address 3) keeps that status bit from driving irq. The status bit is still recorded. irq is high whenever an unmasked status bit is set.
- R10: An abort strobe ends the frame like a frame end, but gives a status byte with bit 4 set and bits 7 and 5 clear, whatever the CRC input.
- R11: A byte that arrives in the same cycle as the release of a full block is stored as the first byte of the new block. A byte that arrives in the same cycle as a frame end is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inByteVld | input | 1 | A received byte is present on inByte |
| inByte | input | 8 | Received data byte |
| inFrameEnd | input | 1 | One-cycle strobe: frame closed normally |
| inCrcOk | input | 1 | CRC verdict, sampled with inFrameEnd |
| inAbort | input | 1 | One-cycle strobe: frame aborted |
| hostAddr | input | 2 | Host register select |
| hostRd | input | 1 | Host read strobe (side effects at the clock edge) |
| hostWr | input | 1 | Host write strobe |
| hostWData | input | 8 | Host write data |
| hostRData | output | 8 | Host read data for hostAddr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first is the clear-on-read of the status register and a new frame-end event. The bench raises the frame-end strobe in the very cycle that reads address 1, then confirms that the value read was empty and that the next read shows 0x80. The second is the release command and an arriving byte. The bench writes the release in the cycle that carries a byte, then checks that the next frame's count is 2 and that the byte is the first one read back.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // host register select
  typedef enum logic [1:0] {
    RegData = 2'd0,
    RegStat = 2'd1,
    RegCmd  = 2'd2,
    RegMask = 2'd3
  } regSel_e;

  // positions inside the interrupt status byte
  localparam int unsigned BitEnd  = 7;
  localparam int unsigned BitFull = 6;
  localparam int unsigned BitOvf  = 5;

  // positions inside the command byte
  localparam int unsigned CmdRel  = 7;
  localparam int unsigned CmdRst  = 6;

  typedef enum logic {
    StFill = 1'b0,
    StHold = 1'b1
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic wrIsStat;
    logic rdClr;
    logic rdPop;
  } rxStrobe_t;

endpackage

// File: rtl/hdlc_rx_dpath.sv
module hdlc_rx_dpath
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxStrobe_t     strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrData,
  output logic [7:0]    rdByte
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rdIdx;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdIdx <= '0;
    else if (strb.rdClr) rdIdx <= '0;
    else if (strb.rdPop) rdIdx <= rdIdx + AW'(1);
  end

  assign rdByte = mem[rdIdx];

endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inByteVld,
  input  logic [7:0]    inByte,
  input  logic          inFrameEnd,
  input  logic          inCrcOk,
  input  logic          inAbort,
  input  logic [1:0]    hostAddr,
  input  logic          hostRd,
  input  logic          hostWr,
  input  logic [7:0]    hostWData,
  output rxStrobe_t     strb,
  output logic [AW-1:0] wrAddr,
  output logic [7:0]    wrData,
  output logic [7:0]    intStat,
  output logic [7:0]    maskReg,
  output logic [AW-1:0] cntReg
);

  localparam logic [AW-1:0] LastIdx = AW'(DEPTH - 1);

  rxState_e      state, stateNxt;
  logic [AW-1:0] wrIdx, wrIdxNxt, baseIdx, cntNxt;
  logic          ovfl, ovflNxt, pendEnd, pendEndNxt;
  logic [7:0]    pendStat, pendStatNxt, frameStat;
  logic          evEnd, evFull, evOvf;
  logic          cmdWr, relCmd, rstCmd, statRd, endEv, freeNow;

  assign cmdWr   = hostWr && (hostAddr == RegCmd);
  assign relCmd  = cmdWr && hostWData[CmdRel];
  assign rstCmd  = cmdWr && hostWData[CmdRst];
  assign statRd  = hostRd && (hostAddr == RegStat);
  assign endEv   = inFrameEnd || inAbort;
  // status byte: not-aborted, dropped byte, crc good, aborted
  assign frameStat = {~inAbort, ovfl, inCrcOk & ~inAbort, inAbort, 4'b0000};
  assign freeNow = (state == StFill) || (relCmd && !pendEnd);
  assign baseIdx = (state == StFill) ? wrIdx : '0;

  always_comb begin
    stateNxt      = state;
    wrIdxNxt      = wrIdx;
    ovflNxt       = ovfl;
    pendEndNxt    = pendEnd;
    pendStatNxt   = pendStat;
    cntNxt        = cntReg;
    evEnd         = 1'b0;
    evFull        = 1'b0;
    evOvf         = 1'b0;
    strb.wrEn     = 1'b0;
    strb.wrIsStat = 1'b0;
    strb.rdClr    = relCmd || rstCmd;
    strb.rdPop    = hostRd && (hostAddr == RegData);
    wrAddr        = baseIdx;
    wrData        = inByte;

    if (rstCmd) begin
      stateNxt   = StFill;
      wrIdxNxt   = '0;
      ovflNxt    = 1'b0;
      pendEndNxt = 1'b0;
    end else if (relCmd && pendEnd) begin
      // deliver the held-back status as a one-byte block
      strb.wrEn     = 1'b1;
      strb.wrIsStat = 1'b1;
      wrAddr        = '0;
      wrData        = pendStat;
      cntNxt        = AW'(1);
      evEnd         = 1'b1;
      wrIdxNxt      = '0;
      pendEndNxt    = 1'b0;
      stateNxt      = StHold;
      if (endEv) begin
        pendEndNxt  = 1'b1;
        pendStatNxt = frameStat;
        ovflNxt     = 1'b0;
      end else if (inByteVld) begin
        evOvf   = 1'b1;
        ovflNxt = 1'b1;
      end
    end else if (freeNow) begin
      stateNxt = StFill;
      wrIdxNxt = baseIdx;
      if (endEv) begin
        strb.wrEn     = 1'b1;
        strb.wrIsStat = 1'b1;
        wrData        = frameStat;
        cntNxt        = baseIdx + AW'(1);
        evEnd         = 1'b1;
        ovflNxt       = 1'b0;
        wrIdxNxt      = '0;
        stateNxt      = StHold;
      end else if (inByteVld) begin
        strb.wrEn = 1'b1;
        if (baseIdx == LastIdx) begin
          stateNxt = StHold;
          evFull   = 1'b1;
          wrIdxNxt = '0;
        end else begin
          wrIdxNxt = baseIdx + AW'(1);
        end
      end
    end else begin
      if (endEv) begin
        if (pendEnd) begin
          evOvf = 1'b1;
        end else begin
          pendEndNxt  = 1'b1;
          pendStatNxt = frameStat;
          ovflNxt     = 1'b0;
        end
      end else if (inByteVld) begin
        evOvf   = 1'b1;
        ovflNxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= StFill;
      wrIdx    <= '0;
      ovfl     <= 1'b0;
      pendEnd  <= 1'b0;
      pendStat <= '0;
      cntReg   <= '0;
      intStat  <= '0;
      maskReg  <= '0;
    end else begin
      state    <= stateNxt;
      wrIdx    <= wrIdxNxt;
      ovfl     <= ovflNxt;
      pendEnd  <= pendEndNxt;
      pendStat <= pendStatNxt;
      cntReg   <= cntNxt;
      intStat  <= (statRd ? 8'h00 : intStat)
                | ({7'd0, evEnd}  << BitEnd)
                | ({7'd0, evFull} << BitFull)
                | ({7'd0, evOvf}  << BitOvf);
      if (hostWr && (hostAddr == RegMask)) maskReg <= hostWData;
    end
  end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inByteVld,
  input  logic [7:0] inByte,
  input  logic       inFrameEnd,
  input  logic       inCrcOk,
  input  logic       inAbort,
  input  logic [1:0] hostAddr,
  input  logic       hostRd,
  input  logic       hostWr,
  input  logic [7:0] hostWData,
  output logic [7:0] hostRData,
  output logic       irq
);

  localparam int unsigned AW = $clog2(DEPTH);

  rxStrobe_t     strb;
  logic [AW-1:0] wrAddr;
  logic [7:0]    wrData;
  logic [7:0]    intStat;
  logic [7:0]    maskReg;
  logic [AW-1:0] cntReg;
  logic [7:0]    rdByte;

  hdlc_rx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inByteVld  (inByteVld),
    .inByte     (inByte),
    .inFrameEnd (inFrameEnd),
    .inCrcOk    (inCrcOk),
    .inAbort    (inAbort),
    .hostAddr   (hostAddr),
    .hostRd     (hostRd),
    .hostWr     (hostWr),
    .hostWData  (hostWData),
    .strb       (strb),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .intStat    (intStat),
    .maskReg    (maskReg),
    .cntReg     (cntReg)
  );

  hdlc_rx_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdByte (rdByte)
  );

  always_comb begin
    case (hostAddr)
      RegData: hostRData = rdByte;
      RegStat: hostRData = intStat;
      RegCmd:  hostRData = 8'(cntReg);
      default: hostRData = maskReg;
    endcase
  end

  assign irq = |(intStat & ~maskReg);

endmodule

// File: rtl/hdlc_rx_fifo_chk.sv
module hdlc_rx_fifo_chk
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rstN,
  input logic          inByteVld,
  input logic          inFrameEnd,
  input logic          inAbort,
  input logic [1:0]    hostAddr,
  input logic          hostRd,
  input logic          hostWr,
  input logic [7:0]    hostWData,
  input rxStrobe_t     strb,
  input logic [AW-1:0] wrAddr,
  input logic [7:0]    intStat,
  input logic          irq
);

  localparam logic [AW-1:0] LastIdx = AW'(DEPTH - 1);

  // R3: the last data slot written raises the block-full bit
  a_r3_full_event: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.wrIsStat && wrAddr == LastIdx) |=> intStat[BitFull]);

  // R4: storing a status byte raises the frame-end bit
  a_r4_end_event: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrIsStat) |=> intStat[BitEnd]);

  // R3: an overflow bit only appears after incoming traffic
  a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStat[BitOvf]) |-> $past(inByteVld || inFrameEnd || inAbort));

  // R8: a quiet status read leaves nothing behind
  a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == RegStat && !inByteVld && !inFrameEnd && !inAbort &&
     !(hostWr && hostAddr == RegCmd && hostWData[CmdRel])) |=> (intStat == 8'h00));

  // R9: masking every source silences the interrupt
  a_r9_mask_all: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == RegMask && hostWData == 8'hFF) |=> !irq);

endmodule

bind hdlc_rx_fifo hdlc_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inByteVld  (inByteVld),
  .inFrameEnd (inFrameEnd),
  .inAbort    (inAbort),
  .hostAddr   (hostAddr),
  .hostRd     (hostRd),
  .hostWr     (hostWr),
  .hostWData  (hostWData),
  .strb       (strb),
  .wrAddr     (wrAddr),
  .intStat    (intStat),
  .irq        (irq)
);

// File: tb/test_hdlc_rx_fifo.sv
module test_hdlc_rx_fifo;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inByteVld = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       inFrameEnd = 1'b0;
  logic       inCrcOk = 1'b0;
  logic       inAbort = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic       hostRd = 1'b0;
  logic       hostWr = 1'b0;
  logic [7:0] hostWData = 8'h00;
  logic [7:0] hostRData;
  logic       irq;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hdlc_rx_fifo i_hdlc_rx_fifo (
    .clk(clk), .rstN(rstN), .inByteVld(inByteVld), .inByte(inByte),
    .inFrameEnd(inFrameEnd), .inCrcOk(inCrcOk), .inAbort(inAbort),
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWData(hostWData), .hostRData(hostRData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int len, input int idx);
    return 8'(len * 37 + idx * 5 + 3);
  endfunction

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk); inByteVld = 1'b1; inByte = b;
    @(posedge clk); #1 inByteVld = 1'b0;
  endtask

  task automatic endFrame(input bit crc, input bit ab);
    @(negedge clk); inFrameEnd = !ab; inAbort = ab; inCrcOk = crc;
    @(posedge clk); #1 inFrameEnd = 1'b0; inAbort = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); hostAddr = a; hostRd = 1'b1;
    #1 d = hostRData;
    @(posedge clk); #1 hostRd = 1'b0;
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); hostAddr = a; hostWr = 1'b1; hostWData = v;
    @(posedge clk); #1 hostWr = 1'b0;
  endtask

  task automatic pushBlock(input int len);
    for (int i = 0; i < 32; i++) pushByte(pat(len, i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChk - nBad, nChk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int r;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    #1 chk("R1 irq", irq, 0);
    hostRead(2'd1, d); chk("R1 status", d, 8'h00);
    hostRead(2'd2, d); chk("R1 count", d, 8'h00);
    hostRead(2'd3, d); chk("R1 mask", d, 8'h00);

    // R2 R3 R4 R5: sweep every frame length from empty to over two blocks
    for (int len = 0; len <= 70; len++) begin
      bit crc;
      crc = len[0];
      for (int i = 0; i < len; i++) begin
        pushByte(pat(len, i));
        if (i % 32 == 31) begin
          chk("R9 irq on full block", irq, 1);
          hostRead(2'd1, d); chk("R3 full-block status", d, 8'h40);
          for (int k = 0; k < 32; k++) begin
            hostRead(2'd0, d); chk("R2 block byte", d, pat(len, i - 31 + k));
          end
          hostWrite(2'd2, 8'h80);
        end
      end
      endFrame(crc, 1'b0);
      r = len % 32;
      chk("R4 irq on frame end", irq, 1);
      hostRead(2'd1, d); chk("R4 end status", d, 8'h80);
      hostRead(2'd2, d); chk("R5 residual count", d, (r + 1) % 32);
      for (int k = 0; k < r; k++) begin
        hostRead(2'd0, d); chk("R2 tail byte", d, pat(len, len - r + k));
      end
      hostRead(2'd0, d); chk("R4 status byte", d, crc ? 8'hA0 : 8'h80);
      hostWrite(2'd2, 8'h80);
    end

    // R3 overflow and R6 held-back frame end
    pushBlock(100);
    hostRead(2'd1, d); chk("R3 full before overflow", d, 8'h40);
    pushByte(8'hEE);
    hostRead(2'd1, d); chk("R3 overflow status", d, 8'h20);
    endFrame(1'b1, 1'b0);
    hostRead(2'd1, d); chk("R6 no event while held", d, 8'h00);
    hostWrite(2'd2, 8'h80);
    hostRead(2'd1, d); chk("R6 end after release", d, 8'h80);
    hostRead(2'd2, d); chk("R6 count one", d, 8'h01);
    hostRead(2'd0, d); chk("R6 status with drop mark", d, 8'hE0);
    hostWrite(2'd2, 8'h80);

    // R7 receiver reset mid frame
    for (int i = 0; i < 5; i++) pushByte(8'hC0 + 8'(i));
    hostWrite(2'd2, 8'h40);
    pushByte(8'h11); pushByte(8'h22); pushByte(8'h33);
    endFrame(1'b1, 1'b0);
    hostRead(2'd1, d); chk("R7 status after reset", d, 8'h80);
    hostRead(2'd2, d); chk("R7 count", d, 8'h04);
    hostRead(2'd0, d); chk("R7 byte0", d, 8'h11);
    hostRead(2'd0, d); chk("R7 byte1", d, 8'h22);
    hostRead(2'd0, d); chk("R7 byte2", d, 8'h33);
    hostRead(2'd0, d); chk("R7 status byte", d, 8'hA0);
    hostWrite(2'd2, 8'h80);

    // R7 reset drops a held-back frame end
    pushBlock(101);
    hostRead(2'd1, d); chk("R7 full", d, 8'h40);
    endFrame(1'b0, 1'b0);
    hostWrite(2'd2, 8'h40);
    hostRead(2'd1, d); chk("R7 held end dropped", d, 8'h00);
    pushByte(8'h44);
    endFrame(1'b1, 1'b0);
    hostRead(2'd1, d); chk("R7 next frame end", d, 8'h80);
    hostRead(2'd2, d); chk("R7 next count", d, 8'h02);
    hostRead(2'd0, d); chk("R7 next byte", d, 8'h44);
    hostRead(2'd0, d); chk("R7 next status", d, 8'hA0);
    hostWrite(2'd2, 8'h80);

    // R8 status read in the same cycle as a frame end
    pushByte(8'h31); pushByte(8'h32);
    @(negedge clk); hostAddr = 2'd1; hostRd = 1'b1; inFrameEnd = 1'b1; inCrcOk = 1'b1;
    #1 d = hostRData;
    @(posedge clk); #1 hostRd = 1'b0; inFrameEnd = 1'b0;
    chk("R8 read before event", d, 8'h00);
    hostRead(2'd1, d); chk("R8 event survives read", d, 8'h80);
    hostRead(2'd1, d); chk("R8 cleared", d, 8'h00);
    hostRead(2'd2, d); chk("R8 count", d, 8'h03);
    hostWrite(2'd2, 8'h80);

    // R9 mask keeps irq low, status still recorded
    hostWrite(2'd3, 8'h80);
    hostRead(2'd3, d); chk("R9 mask readback", d, 8'h80);
    endFrame(1'b1, 1'b0);
    #1 chk("R9 masked irq", irq, 0);
    hostRead(2'd1, d); chk("R9 status recorded", d, 8'h80);
    hostRead(2'd2, d); chk("R9 empty frame count", d, 8'h01);
    hostRead(2'd0, d); chk("R9 status byte", d, 8'hA0);
    hostWrite(2'd2, 8'h80);
    hostWrite(2'd3, 8'h00);

    // R10 abort
    pushByte(8'h51); pushByte(8'h52);
    endFrame(1'b1, 1'b1);
    hostRead(2'd1, d); chk("R10 end status", d, 8'h80);
    hostRead(2'd2, d); chk("R10 count", d, 8'h03);
    hostRead(2'd0, d); chk("R10 byte0", d, 8'h51);
    hostRead(2'd0, d); chk("R10 byte1", d, 8'h52);
    hostRead(2'd0, d); chk("R10 abort status byte", d, 8'h10);
    hostWrite(2'd2, 8'h80);

    // R11 byte in the release cycle is kept
    pushBlock(102);
    hostRead(2'd1, d); chk("R11 full", d, 8'h40);
    @(negedge clk); hostAddr = 2'd2; hostWr = 1'b1; hostWData = 8'h80;
    inByteVld = 1'b1; inByte = 8'h5A;
    @(posedge clk); #1 hostWr = 1'b0; inByteVld = 1'b0;
    endFrame(1'b0, 1'b0);
    hostRead(2'd1, d); chk("R11 end status", d, 8'h80);
    hostRead(2'd2, d); chk("R11 count", d, 8'h02);
    hostRead(2'd0, d); chk("R11 kept byte", d, 8'h5A);
    hostRead(2'd0, d); chk("R11 status byte", d, 8'h80);
    hostRead(2'd0, d);
    hostWrite(2'd2, 8'h80);
    hostRead(2'd0, d); chk("R2 release rewinds read", d, 8'h5A);
    hostWrite(2'd2, 8'h80);

    // R11 byte alongside a frame end is discarded
    @(negedge clk); inByteVld = 1'b1; inByte = 8'h77; inFrameEnd = 1'b1; inCrcOk = 1'b1;
    @(posedge clk); #1 inByteVld = 1'b0; inFrameEnd = 1'b0;
    hostRead(2'd1, d); chk("R11 end with byte", d, 8'h80);
    hostRead(2'd2, d); chk("R11 byte dropped count", d, 8'h01);
    hostRead(2'd0, d); chk("R11 only status", d, 8'hA0);
    hostWrite(2'd2, 8'h80);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nBad, nChk);
    $finish;
  end

endmodule